// File: doc/BRIEF.md
# Multi-Mode Phase-Counting Channel

This block is one 16-bit up/down counter channel. Two external phase signals drive it, and it can decode them in three ways: full quadrature with four counts per cycle, pulse plus direction level, or two counts per cycle taken from phase B edges only. A select bit chooses which of two pin pairs feeds the decoder. The counter tracks the direction of its most recent step in a status flag. It clears to zero when it counts up past a programmable ceiling, and it reloads the ceiling when it counts down from zero.

Software programs the channel through a small synchronous register port. A single write strobe with an address and write data changes one register. The read data is a combinational function of the address. Each phase input passes through a two-flop synchronizer before edge detection, so a pin change reaches the count on the third rising clock edge after it.

Top module: `qpc_channel`

## Requirements
- R1: After reset the count reads 0, the mode register reads 4, the control register reads 0, the ceiling reads 0xFFFF and the status register reads 0. The register addresses are: count 0, mode 1, control 2, ceiling 3, status 4.
- R2: With mode 4 (x4 quadrature), each single-phase edge on A or B changes the count by one. The count goes up when the new level of A differs from the old level of B, and down otherwise. With this rule, the pin sequence AB = 00, 10, 11, 01 counts up.
- R3: With mode 5 (pulse/direction), only a rising edge of A changes the count. It counts up when B is 1 and down when B is 0. Falling edges of A and any edge of B do not count.
- R4: With mode 7 (x2 on B), each edge of B changes the count, with direction given by the same rule as R2. Edges of A do not count.
- R5: In mode 4 or mode 7, if A and B change in the same clock cycle, the transition is invalid and does not change the count.
- R6: Status bit 7 reads 1 after an up step and 0 after a down step.
- R7: An up step taken while the count equals the ceiling sets the count to 0.
- R8: A down step taken while the count is 0 sets the count to the ceiling value.
- R9: Control bit 0 enables counting. While it is 0, phase edges change neither the count nor the direction flag.
- R10: A write to the count register takes effect on the next clock. A count event in that same cycle is dropped, and the direction flag keeps its value.
- R11: Control bit 1 selects the pin pair: 0 selects pins A/B and 1 selects pins C/D. Edges on the pair that is not selected do not count.
- R12: The mode register stores the low 4 bits of the write data and reads 0 in its upper bits. Any mode value other than 4, 5 or 7 (including the reserved values 6 and 9) produces no counting.
- R13: The ceiling register reads back the last value written to it. Writes to the status register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ph_a | input | 1 | Pair 0, phase A pin (asynchronous) |
| ph_b | input | 1 | Pair 0, phase B pin (asynchronous) |
| ph_c | input | 1 | Pair 1, phase A pin (asynchronous) |
| ph_d | input | 1 | Pair 1, phase B pin (asynchronous) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr (combinational) |

## Verification
A wrong decoder or direction rule appears as a count off by one step on the third clock after the offending pin edge, and the status bit 7 read in the same window also shows it. A bad ceiling compare or bad zero-wrap state becomes visible at the single step that crosses the boundary, because the count read there is wrong. A priority or gating error shows right after the stimulus: the count either moves when it should hold, or holds when it should take the written value. The sweeps walk every mode through both directions and through the boundaries, so each of these errors is caught within a few cycles of its cause.

// File: rtl/qpc_pkg.sv
package qpc_pkg;

    localparam logic [3:0] MODE_X4  = 4'd4;
    localparam logic [3:0] MODE_PD  = 4'd5;
    localparam logic [3:0] MODE_X2B = 4'd7;

    localparam int DIR_BIT = 7;
    localparam int EN_BIT  = 0;
    localparam int SEL_BIT = 1;

    typedef enum logic [2:0] {
        RA_COUNT = 3'd0,
        RA_MODE  = 3'd1,
        RA_CTRL  = 3'd2,
        RA_CEIL  = 3'd3,
        RA_STAT  = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic a;
        logic b;
    } phase_t;

    typedef struct packed {
        logic valid;
        logic up;
    } step_t;

    // Turns one sampled phase transition into a count step, according to the mode.
    function automatic step_t phase_step(logic [3:0] mode, phase_t prv, phase_t cur);
        step_t s;
        logic  da;
        logic  db;
        s.valid = 1'b0;
        s.up    = 1'b0;
        da = prv.a ^ cur.a;
        db = prv.b ^ cur.b;
        case (mode)
            MODE_X4: begin
                if (da ^ db) begin
                    s.valid = 1'b1;
                    s.up    = cur.a ^ prv.b;
                end
            end
            MODE_X2B: begin
                if (db && !da) begin
                    s.valid = 1'b1;
                    s.up    = cur.a ^ prv.b;
                end
            end
            MODE_PD: begin
                if (!prv.a && cur.a) begin
                    s.valid = 1'b1;
                    s.up    = cur.b;
                end
            end
            default: begin
                s.valid = 1'b0;
            end
        endcase
        return s;
    endfunction

endpackage

// File: rtl/qpc_sync.sv
module qpc_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) begin
                chain <= '0;
            end else begin
                chain <= {chain[STAGES-2:0], d_in[i]};
            end
        end
        assign d_out[i] = chain[STAGES-1];
    end
endmodule

// File: rtl/qpc_decoder.sv
module qpc_decoder
    import qpc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] mode,
    input  phase_t     ph_now,
    output step_t      step
);
    phase_t ph_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_prev <= '0;
        end else begin
            ph_prev <= ph_now;
        end
    end

    always_comb begin
        step = phase_step(mode, ph_prev, ph_now);
    end
endmodule

// File: rtl/qpc_core.sv
module qpc_core
    import qpc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  step_t            step,
    input  logic [CNT_W-1:0] ceiling,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             dir_up
);
    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] up_next;
    logic [CNT_W-1:0] dn_next;

    always_comb begin
        up_next = (count == ceiling) ? ZERO : count + ONE;
        dn_next = (count == ZERO) ? ceiling : count - ONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count  <= ZERO;
            dir_up <= 1'b0;
        end else if (load) begin
            count <= load_val;
        end else if (enable && step.valid) begin
            dir_up <= step.up;
            count  <= step.up ? up_next : dn_next;
        end
    end
endmodule

// File: rtl/qpc_regs.sv
module qpc_regs
    import qpc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [2:0]       addr,
    input  logic [CNT_W-1:0] wdata,
    input  logic [CNT_W-1:0] count,
    input  logic             dir_up,
    output logic [CNT_W-1:0] rdata,
    output logic [3:0]       mode,
    output logic             enable,
    output logic             pair_sel,
    output logic [CNT_W-1:0] ceiling,
    output logic             count_load
);
    reg_addr_e a_e;

    always_comb begin
        a_e        = reg_addr_e'(addr);
        count_load = we && (a_e == RA_COUNT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode     <= MODE_X4;
            enable   <= 1'b0;
            pair_sel <= 1'b0;
            ceiling  <= '1;
        end else if (we) begin
            case (a_e)
                RA_MODE: mode <= wdata[3:0];
                RA_CTRL: begin
                    enable   <= wdata[EN_BIT];
                    pair_sel <= wdata[SEL_BIT];
                end
                RA_CEIL: ceiling <= wdata;
                default: begin
                end
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (a_e)
            RA_COUNT: rdata = count;
            RA_MODE:  rdata[3:0] = mode;
            RA_CTRL: begin
                rdata[EN_BIT]  = enable;
                rdata[SEL_BIT] = pair_sel;
            end
            RA_CEIL:  rdata = ceiling;
            RA_STAT:  rdata[DIR_BIT] = dir_up;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/qpc_channel.sv
module qpc_channel
    import qpc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ph_a,
    input  logic             ph_b,
    input  logic             ph_c,
    input  logic             ph_d,
    input  logic             reg_we,
    input  logic [2:0]       reg_addr,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata
);
    logic [3:0]       mode_q;
    logic             cnt_en;
    logic             pair_sel;
    logic [CNT_W-1:0] ceil_q;
    logic             cnt_wr;
    logic [CNT_W-1:0] cnt_q;
    logic             dir_q;
    logic [1:0]       pins_raw;
    logic [1:0]       pins_sync;
    phase_t           ph_now;
    step_t            step_s;
    logic             step_v;
    logic             step_up;

    assign pins_raw = pair_sel ? {ph_c, ph_d} : {ph_a, ph_b};

    qpc_sync #(.WIDTH(2), .STAGES(2)) sync_i (
        .clk   (clk),
        .rst   (rst),
        .d_in  (pins_raw),
        .d_out (pins_sync)
    );

    assign ph_now.a = pins_sync[1];
    assign ph_now.b = pins_sync[0];

    qpc_decoder dec_i (
        .clk    (clk),
        .rst    (rst),
        .mode   (mode_q),
        .ph_now (ph_now),
        .step   (step_s)
    );

    assign step_v  = step_s.valid;
    assign step_up = step_s.up;

    qpc_core #(.CNT_W(CNT_W)) core_i (
        .clk      (clk),
        .rst      (rst),
        .enable   (cnt_en),
        .step     (step_s),
        .ceiling  (ceil_q),
        .load     (cnt_wr),
        .load_val (reg_wdata),
        .count    (cnt_q),
        .dir_up   (dir_q)
    );

    qpc_regs #(.CNT_W(CNT_W)) regs_i (
        .clk        (clk),
        .rst        (rst),
        .we         (reg_we),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .count      (cnt_q),
        .dir_up     (dir_q),
        .rdata      (reg_rdata),
        .mode       (mode_q),
        .enable     (cnt_en),
        .pair_sel   (pair_sel),
        .ceiling    (ceil_q),
        .count_load (cnt_wr)
    );
endmodule

// File: rtl/qpc_checker.sv
module qpc_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] ceil,
    input logic [CNT_W-1:0] wdata,
    input logic             en,
    input logic             cnt_wr,
    input logic             step_v,
    input logic             step_up,
    input logic             dir
);
    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    // R1: state right after a reset cycle
    always @(posedge clk) begin
        if (rst_d == 1'b1) begin
            a_r1_reset_state: assert (cnt == '0 && ceil == '1 && dir == 1'b0)
                else $error("R1 reset state wrong");
        end
    end

    a_r7_clear_at_ceiling: assert property (@(posedge clk) disable iff (rst)
        (en && step_v && step_up && !cnt_wr && cnt == ceil) |=> (cnt == '0));

    a_r8_wrap_to_ceiling: assert property (@(posedge clk) disable iff (rst)
        (en && step_v && !step_up && !cnt_wr && cnt == '0) |=> (cnt == $past(ceil)));

    a_r6_dir_follows_step: assert property (@(posedge clk) disable iff (rst)
        (en && step_v && !cnt_wr) |=> (dir == $past(step_up)));

    a_r9_hold_when_disabled: assert property (@(posedge clk) disable iff (rst)
        (!en && !cnt_wr) |=> ($stable(cnt) && $stable(dir)));

    a_r10_write_wins: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> (cnt == $past(wdata) && $stable(dir)));
endmodule

bind qpc_channel qpc_checker #(.CNT_W(CNT_W)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .cnt     (cnt_q),
    .ceil    (ceil_q),
    .wdata   (reg_wdata),
    .en      (cnt_en),
    .cnt_wr  (cnt_wr),
    .step_v  (step_v),
    .step_up (step_up),
    .dir     (dir_q)
);

// File: tb/qpc_channel_tb.sv
`timescale 1ns/1ps
module qpc_channel_tb_top;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         pa = 0, pb = 0, pc = 0, pd = 0;
    logic         reg_we = 0;
    logic [2:0]   reg_addr = 0;
    logic [W-1:0] reg_wdata = 0;
    logic [W-1:0] reg_rdata;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // bench model state
    int  m_mode = 4;
    bit  m_en   = 0;
    bit  m_sel  = 0;
    int  m_cnt  = 0;
    int  m_ceil = 65535;
    bit  m_dir  = 0;
    bit  ma = 0, mb = 0;

    always #10 clk = ~clk;

    qpc_channel #(.CNT_W(W)) dut_i (
        .clk(clk), .rst(rst), .ph_a(pa), .ph_b(pb), .ph_c(pc), .ph_d(pd),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(int addr, int data);
        @(negedge clk);
        reg_we = 1; reg_addr = addr[2:0]; reg_wdata = data[W-1:0];
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic rd(int addr, output int val);
        @(negedge clk);
        reg_addr = addr[2:0];
        #1 val = int'(reg_rdata);
    endtask

    function automatic int exp_delta(int mode, bit oa, bit ob, bit na, bit nb);
        bit ca = (oa != na);
        bit cb = (ob != nb);
        if (mode == 4 && (ca != cb)) return (na != ob) ? 1 : -1;
        if (mode == 7 && cb && !ca) return (na != ob) ? 1 : -1;
        if (mode == 5 && !oa && na) return nb ? 1 : -1;
        return 0;
    endfunction

    function automatic void apply(int d);
        if (!m_en || d == 0) return;
        m_dir = (d > 0);
        if (d > 0) m_cnt = (m_cnt == m_ceil) ? 0 : m_cnt + 1;
        else       m_cnt = (m_cnt == 0) ? m_ceil : m_cnt - 1;
    endfunction

    task automatic drive_sel(bit a, bit b);
        if (m_sel) begin pc = a; pd = b; end
        else       begin pa = a; pb = b; end
    endtask

    // move the selected pair and check count and direction
    task automatic move(bit na, bit nb, string req);
        int v;
        apply(exp_delta(m_mode, ma, mb, na, nb));
        ma = na; mb = nb;
        @(negedge clk);
        drive_sel(na, nb);
        repeat (4) @(negedge clk);
        rd(0, v);
        check(req, v, m_cnt);
        rd(4, v);
        check({req, " R6 dir"}, v, m_dir ? 32'h80 : 0);
    endtask

    task automatic quad_up(int n, string req);
        for (int i = 0; i < n; i++) begin
            case ({ma, mb})
                2'b00: move(1, 0, req);
                2'b10: move(1, 1, req);
                2'b11: move(0, 1, req);
                default: move(0, 0, req);
            endcase
        end
    endtask

    task automatic quad_dn(int n, string req);
        for (int i = 0; i < n; i++) begin
            case ({ma, mb})
                2'b00: move(0, 1, req);
                2'b01: move(1, 1, req);
                2'b11: move(1, 0, req);
                default: move(0, 0, req);
            endcase
        end
    endtask

    task automatic set_mode(int m);
        wr(1, m);
        m_mode = m & 15;
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset values
        rd(0, v); check("R1 count", v, 0);
        rd(1, v); check("R1 mode", v, 4);
        rd(2, v); check("R1 ctrl", v, 0);
        rd(3, v); check("R1 ceiling", v, 16'hFFFF);
        rd(4, v); check("R1 status", v, 0);

        // R9 disabled after reset: edges do not count
        move(1, 0, "R9 disabled");
        move(0, 0, "R9 disabled");

        wr(2, 1); m_en = 1;

        // R2 x4 quadrature both directions
        quad_up(9, "R2 x4 up");
        quad_dn(13, "R2 x4 down");
        quad_up(3, "R2 x4 up again");

        // R5 simultaneous change in x4
        if (ma == mb) move(!ma, !mb, "R5 x4 both change");
        else          move(!ma, !mb, "R5 x4 both change");
        quad_up(2, "R5 after invalid");

        // R3 pulse/direction: sweep all transitions
        set_mode(5);
        for (int k = 0; k < 16; k++) begin
            move(k[0], k[1], "R3 pulse/dir");
            move(k[2], k[3], "R3 pulse/dir");
        end

        // R4 x2 on B
        set_mode(7);
        for (int k = 0; k < 16; k++) begin
            move(k[0], k[1], "R4/R5 x2b");
            move(k[2], k[3], "R4/R5 x2b");
        end

        // R12 reserved and unknown modes
        set_mode(6);
        rd(1, v); check("R12 mode readback", v, 6);
        quad_up(4, "R12 mode 6");
        wr(1, 16'hFFF9); m_mode = 9;
        rd(1, v); check("R12 mode low bits", v, 9);
        quad_dn(4, "R12 mode 9");
        set_mode(0);
        quad_up(2, "R12 mode 0");

        // R13 ceiling readback, R7 / R8 boundaries
        set_mode(4);
        wr(3, 5); m_ceil = 5;
        rd(3, v); check("R13 ceiling", v, 5);
        wr(0, 3); m_cnt = 3;
        rd(0, v); check("R10 count write", v, 3);
        quad_up(4, "R7 clear at ceiling");
        quad_dn(4, "R8 wrap to ceiling");

        // R13 status write ignored
        rd(4, v);
        wr(4, 16'h0000);
        begin
            int v2;
            rd(4, v2); check("R13 status write ignored", v2, v);
        end

        // R9 enable off holds count and direction
        wr(2, 0); m_en = 0;
        quad_up(3, "R9 hold");
        quad_dn(1, "R9 hold");
        wr(2, 1); m_en = 1;
        quad_up(1, "R9 re-enabled");

        // R10 write in the same cycle as a count event
        wr(3, 16'hFFFF); m_ceil = 65535;
        begin
            bit na, nb;
            na = !ma; nb = mb;
            @(negedge clk);
            drive_sel(na, nb);
            ma = na; mb = nb;
            @(negedge clk);
            @(negedge clk);
            reg_we = 1; reg_addr = 0; reg_wdata = 16'd100;
            @(negedge clk);
            reg_we = 0;
            m_cnt = 100;
            repeat (3) @(negedge clk);
            rd(0, v); check("R10 event dropped", v, 100);
            rd(4, v); check("R10 dir kept", v, m_dir ? 32'h80 : 0);
        end

        // R11 pin pair select
        @(negedge clk); pc = ma; pd = mb;
        wr(2, 3); m_sel = 1;
        repeat (3) @(negedge clk);
        rd(0, v); check("R11 switch no count", v, m_cnt);
        @(negedge clk); pa = !pa;
        repeat (4) @(negedge clk);
        rd(0, v); check("R11 unselected A/B ignored", v, m_cnt);
        @(negedge clk); pb = !pb;
        repeat (4) @(negedge clk);
        rd(0, v); check("R11 unselected A/B ignored", v, m_cnt);
        quad_up(3, "R11 C/D counts");
        quad_dn(5, "R11 C/D counts");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule